// File: doc/BRIEF.md
# Start-Time Fair Queuing Rank Computer

This block assigns a scheduling rank to every arriving packet so that a downstream sorted queue can serve flows fairly. Each packet arrives with a flow index, a length and the current virtual time. The block looks up the finish time last recorded for that flow. It takes as the packet's start time whichever of that finish time and the virtual time lies later. It emits the start time as the rank, and records start plus length as the flow's new finish time.

The block takes one packet per cycle on a valid/ready input and presents the rank on a registered output in the following cycle. Writes to the finish table land one cycle after acceptance. The block therefore forwards a pending write to a packet of the same flow that follows directly, so that packet sees the value just computed. A synchronous clear returns every finish time to zero. Time arithmetic wraps modulo 2^32. The "later of two times" test is a serial-number comparison, so the block keeps working across the wrap.

Top module: `sfq_rank_unit`

## Requirements
- R1: After reset, out_valid is 0 and every flow's stored finish time is 0. The first packet of any flow therefore ranks at the later of 0 and its virtual time.
- R2: in_ready is 1 whenever clr_i is 0 and 0 whenever clr_i is 1. A packet is accepted only in a cycle where in_valid and in_ready are both 1.
- R3: A packet accepted at a clock edge appears at that edge on out_valid=1, with out_flow equal to its flow index. The result is therefore visible one cycle after the packet was presented.
- R4: out_rank is the later of the flow's stored finish F and the virtual time V. F is later when (F - V) mod 2^32 is below 2^31, and V is later otherwise.
- R5: After a packet is accepted, the flow's stored finish time becomes (rank + length) mod 2^32, where the length is zero-extended.
- R6: A packet accepted in the cycle right after an earlier packet of the same flow uses the finish time that earlier packet produced.
- R7: A packet changes only its own flow's finish time. Other flows keep theirs.
- R8: While clr_i is 1, every stored finish time returns to 0. A packet presented in that cycle is not accepted and produces no output.
- R9: The finish-time sum and the later-of comparison both wrap correctly near 2^32.
- R10: out_valid is 0 in any cycle after an edge at which no packet was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all finish times |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Block can accept a packet |
| in_flow | input | FLOW_W (6) | Flow index |
| in_len | input | LEN_W (16) | Packet length |
| in_vtime | input | 32 | Current virtual time |
| out_valid | output | 1 | Rank result valid |
| out_flow | output | FLOW_W (6) | Flow index of the result |
| out_rank | output | 32 | Packet rank (start time) |

## Verification
The bench builds the block with its default parameters: 64 flows, 16-bit lengths and 32-bit time. The flow index then covers the whole table, including its first and last entries. The bench drives virtual times close to 2^32 and finish times that sit 2^31 apart from them. This exercises the serial comparison and the wrap of the finish sum. Back-to-back packets on one flow exercise the forwarding path. Packets alternating across flows confirm that forwarding fires only when the flow index matches.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
  parameter int SFQ_TIME_W = 32;
  typedef logic [SFQ_TIME_W-1:0] vtime_t;

  // True when a lies at or after b in wrapping serial order.
  function automatic logic sfq_not_before(vtime_t a, vtime_t b);
    vtime_t d;
    d = a - b;
    return !d[SFQ_TIME_W-1];
  endfunction

  function automatic vtime_t sfq_later(vtime_t fin, vtime_t vt);
    return sfq_not_before(fin, vt) ? fin : vt;
  endfunction

  function automatic vtime_t sfq_finish(vtime_t start, vtime_t len);
    return start + len;
  endfunction
endpackage

// File: rtl/sfq_finish_table.sv
module sfq_finish_table
  import sfq_pkg::*;
#(
  parameter int FLOWS = 64,
  parameter int IDX_W = $clog2(FLOWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  vtime_t           wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output vtime_t           rd_data
);
  vtime_t entry_q [FLOWS];

  for (genvar g = 0; g < FLOWS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  entry_q[g] <= '0;
      else if (clr_i)                              entry_q[g] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))     entry_q[g] <= wr_data;
    end
  end

  assign rd_data = entry_q[rd_idx];
endmodule

// File: rtl/sfq_fwd_sel.sv
module sfq_fwd_sel
  import sfq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             pend_valid,
  input  logic [IDX_W-1:0] pend_idx,
  input  vtime_t           pend_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  vtime_t           tbl_data,
  output vtime_t           sel_data,
  output logic             hit
);
  always_comb begin
    hit      = pend_valid && (pend_idx == rd_idx);
    sel_data = hit ? pend_data : tbl_data;
  end
endmodule

// File: rtl/sfq_rank_unit.sv
module sfq_rank_unit
  import sfq_pkg::*;
#(
  parameter int FLOWS  = 64,
  parameter int LEN_W  = 16,
  parameter int FLOW_W = $clog2(FLOWS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [FLOW_W-1:0]     in_flow,
  input  logic [LEN_W-1:0]      in_len,
  input  logic [SFQ_TIME_W-1:0] in_vtime,
  output logic                  out_valid,
  output logic [FLOW_W-1:0]     out_flow,
  output logic [SFQ_TIME_W-1:0] out_rank
);
  logic        accept;
  logic        fwd_hit;
  vtime_t      tbl_fin, prior_fin, start_t, finish_t;

  logic              pend_v_q;
  logic [FLOW_W-1:0] pend_idx_q;
  vtime_t            pend_fin_q;
  logic              out_v_q;
  logic [FLOW_W-1:0] out_flow_q;
  vtime_t            out_rank_q;

  assign in_ready = !clr_i;
  assign accept   = in_valid && in_ready;

  sfq_finish_table #(.FLOWS(FLOWS), .IDX_W(FLOW_W)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr_i),
    .wr_en   (pend_v_q),
    .wr_idx  (pend_idx_q),
    .wr_data (pend_fin_q),
    .rd_idx  (in_flow),
    .rd_data (tbl_fin)
  );

  sfq_fwd_sel #(.IDX_W(FLOW_W)) u_fwd (
    .pend_valid (pend_v_q),
    .pend_idx   (pend_idx_q),
    .pend_data  (pend_fin_q),
    .rd_idx     (in_flow),
    .tbl_data   (tbl_fin),
    .sel_data   (prior_fin),
    .hit        (fwd_hit)
  );

  assign start_t  = sfq_later(prior_fin, vtime_t'(in_vtime));
  assign finish_t = sfq_finish(start_t, vtime_t'(in_len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v_q   <= 1'b0;
      pend_idx_q <= '0;
      pend_fin_q <= '0;
      out_v_q    <= 1'b0;
      out_flow_q <= '0;
      out_rank_q <= '0;
    end else begin
      pend_v_q <= accept;
      out_v_q  <= accept;
      if (accept) begin
        pend_idx_q <= in_flow;
        pend_fin_q <= finish_t;
        out_flow_q <= in_flow;
        out_rank_q <= start_t;
      end
    end
  end

  assign out_valid = out_v_q;
  assign out_flow  = out_flow_q;
  assign out_rank  = out_rank_q;
endmodule

// File: rtl/sfq_rank_chk.sv
module sfq_rank_chk
  import sfq_pkg::*;
#(
  parameter int FLOW_W = 6,
  parameter int LEN_W  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr_i,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [FLOW_W-1:0]     in_flow,
  input logic [LEN_W-1:0]      in_len,
  input logic [SFQ_TIME_W-1:0] in_vtime,
  input logic                  out_valid,
  input logic [FLOW_W-1:0]     out_flow,
  input logic [SFQ_TIME_W-1:0] out_rank,
  input logic                  fwd_hit
);
  // R2
  ready_vs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !clr_i);

  // R3
  out_from_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_flow == $past(in_flow)));

  // R10
  no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);

  // R4
  rank_not_before_vtime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> sfq_not_before(out_rank, $past(in_vtime)));

  // R6
  fwd_same_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |-> (out_valid && out_flow == in_flow));

  // R8
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !out_valid);
endmodule

bind sfq_rank_unit sfq_rank_chk #(.FLOW_W(FLOW_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_flow   (in_flow),
  .in_len    (in_len),
  .in_vtime  (in_vtime),
  .out_valid (out_valid),
  .out_flow  (out_flow),
  .out_rank  (out_rank),
  .fwd_hit   (fwd_hit)
);

// File: tb/sfq_rank_unit_tb.sv
module sfq_rank_unit_tb;
  localparam int FLOWS = 64;
  localparam int FW    = 6;
  localparam int LW    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr_i = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [FW-1:0] in_flow = '0;
  logic [LW-1:0] in_len = '0;
  logic [31:0]   in_vtime = '0;
  logic          out_valid;
  logic [FW-1:0] out_flow;
  logic [31:0]   out_rank;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] ref_fin [FLOWS];

  always #2.5 clk = ~clk;

  sfq_rank_unit u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_flow(in_flow),
    .in_len(in_len), .in_vtime(in_vtime),
    .out_valid(out_valid), .out_flow(out_flow), .out_rank(out_rank)
  );

  function automatic logic [31:0] ref_pick(logic [31:0] f, logic [31:0] v);
    if ($signed(f - v) >= 0) return f;
    return v;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: optionally offer a packet, then check the registered result.
  task automatic pkt(string req, int fl, int len, logic [31:0] vt);
    logic [31:0] exp_rank;
    @(negedge clk);
    in_valid = 1'b1; in_flow = FW'(fl); in_len = LW'(len); in_vtime = vt;
    exp_rank = ref_pick(ref_fin[fl], vt);
    ref_fin[fl] = exp_rank + 32'(len);
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " flow"}, 32'(out_flow), 32'(fl));
    chk({req, " rank"}, out_rank, exp_rank);
  endtask

  task automatic idle_cycle(string req);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk(req, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < FLOWS; i++) ref_fin[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R2 ready after reset", 32'(in_ready), 32'd1);
    pkt("R1 fresh flow 0", 0, 100, 32'd40);
    pkt("R1 fresh flow 63", 63, 8, 32'd0);
  endtask

  task automatic t_basic;
    pkt("R4 vtime later", 3, 50, 32'd1000);
    idle_cycle("R10 idle");
    pkt("R4 finish later", 3, 20, 32'd1010);
    pkt("R5 finish advanced", 3, 5, 32'd0);
    idle_cycle("R10 idle 2");
  endtask

  task automatic t_backtoback;
    pkt("R6 b2b first", 10, 300, 32'd500);
    pkt("R6 b2b second", 10, 70, 32'd510);
    pkt("R6 b2b third", 10, 1, 32'd520);
    pkt("R6 b2b fourth", 10, 65535, 32'd530);
  endtask

  task automatic t_independent;
    pkt("R7 flow 20", 20, 1000, 32'd2000);
    pkt("R7 flow 21", 21, 10, 32'd2000);
    pkt("R7 flow 20 again", 20, 10, 32'd2000);
    pkt("R7 flow 21 again", 21, 10, 32'd2000);
    pkt("R7 flow 10 untouched", 10, 0, 32'd0);
  endtask

  task automatic t_wrap;
    pkt("R9 set high", 5, 0, 32'h7000_0000);
    pkt("R9 higher", 5, 0, 32'hF000_0000);
    pkt("R9 near top", 5, 32, 32'hFFFF_FFF0);
    pkt("R9 wrapped finish wins", 5, 4, 32'h0000_0005);
    pkt("R4 serial vtime across wrap", 5, 0, 32'h0000_0100);
    pkt("R4 vtime half space ahead", 6, 0, 32'h8000_0001);
  endtask

  task automatic t_clear;
    @(negedge clk);
    clr_i = 1'b1; in_valid = 1'b1; in_flow = FW'(10); in_len = 16'd7; in_vtime = 32'd3;
    #1;
    chk("R2 ready low in clear", 32'(in_ready), 32'd0);
    @(posedge clk); #1;
    chk("R8 no output in clear", 32'(out_valid), 32'd0);
    @(negedge clk);
    clr_i = 1'b0; in_valid = 1'b0;
    for (int i = 0; i < FLOWS; i++) ref_fin[i] = '0;
    #1;
    chk("R2 ready back", 32'(in_ready), 32'd1);
    pkt("R8 flow 10 cleared", 10, 4, 32'd3);
    pkt("R8 flow 5 cleared", 5, 4, 32'd9);
  endtask

  task automatic t_clear_pending;
    pkt("R8 write before clear", 30, 900, 32'd50);
    @(negedge clk);
    clr_i = 1'b1;
    @(posedge clk); #1;
    chk("R8 clear cycle idle", 32'(out_valid), 32'd0);
    @(negedge clk);
    clr_i = 1'b0;
    for (int i = 0; i < FLOWS; i++) ref_fin[i] = '0;
    pkt("R8 pending write dropped", 30, 1, 32'd50);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_basic();
    t_backtoback();
    t_independent();
    t_wrap();
    t_clear();
    t_clear_pending();
    repeat (2) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule